// File: doc/BRIEF.md
# Time-Sliced Integrate-and-Fire Neuron

This block models one spiking neuron whose arithmetic is shared in time. The surrounding logic divides its clock and gives a one-cycle `strobe` for each time slice. On that strobe the neuron captures the spike vector on its input lines. It then steps a counter through a small weight store, one entry per clock. Every input that spiked in the slice adds its signed synaptic weight to the membrane potential. One more clock applies a slope that moves the potential back toward rest, decides whether the neuron fires, and closes the slice. No multiplier is used. The weights and the two slopes sit in one array.

The neuron holds exactly two states, operational and refractory. When it fires, the potential drops to an after-spike level and the neuron turns refractory. In the refractory state the potential climbs by the rising slope each slice until it reaches rest again. While refractory, incoming spikes are either discarded or weakened by an arithmetic right shift, chosen by the `refMode` input. Before the first slice, a plain write port loads the store.

Top module: `spike_neuron`

## Requirements
- R1: After reset the potential equals REST (32), the neuron is operational, and `spikeOut` and `sliceDone` are low.
- R2: `sliceDone` pulses high for one clock, NUM_IN+1 clocks after the edge that samples `strobe`. A strobe that arrives while a slice is running is ignored.
- R3: In the operational state, the weight of every input line whose bit in `spikeIn` is 1 is added to the potential, in the same slice.
- R4: In the operational state without firing, a potential above REST falls by the falling slope but stops at REST. A potential below REST rises by the rising slope but stops at REST.
- R5: If the potential after the weights are added is at or above THRESH (128), `spikeOut` is high for exactly one clock, together with `sliceDone`. The potential becomes AFTER (18) and the neuron becomes refractory.
- R6: In the refractory state the potential rises by the rising slope each slice. Once it is at or above REST, the neuron is operational again and keeps that potential.
- R7: With `refMode`=0 (absolute), spikes that arrive in the refractory state have no effect on the potential.
- R8: With `refMode`=1 (partial), a refractory spike adds its weight arithmetically shifted right by ATTEN_SHIFT.
- R9: The potential never goes below LOW_BOUND (-128). Any addition that would fall below it is clamped to it.
- R10: Store address i < NUM_IN holds the weight of input line i. Address NUM_IN holds the rising slope and address NUM_IN+1 holds the falling slope. All entries are signed, written through `wrEn`/`wrAddr`/`wrData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | One-cycle pulse that starts a time slice |
| spikeIn | input | NUM_IN | Input spikes for the slice, sampled with the strobe |
| refMode | input | 1 | 0 = absolute refractoriness, 1 = partial (shifted) |
| wrEn | input | 1 | Store write enable |
| wrAddr | input | AW | Store write address |
| wrData | input | W_BITS | Signed store write data |
| spikeOut | output | 1 | One-cycle output spike |
| sliceDone | output | 1 | One-cycle end-of-slice flag |
| inRefractory | output | 1 | High while the neuron is refractory |
| potOut | output | P_BITS | Signed membrane potential |

## Verification
The bench builds the neuron with NUM_IN=4 and ATTEN_SHIFT=1, so a slice lasts five clocks. A halving attenuation gives exact values that are easy to compute. With only four lines, single weights can push the potential across the threshold, below rest and onto the negative clamp. A slice can therefore show firing, both slope directions, the cap at rest and both refractory modes within a few slices. Clamping is also checked in the middle of a slice.

// File: rtl/neuron_pkg.sv
package neuron_pkg;
  typedef struct packed {
    logic latch;  // capture the spike vector, slice begins
    logic accum;  // add the weight at the current index
    logic slope;  // slope, fire decision, close the slice
  } ctrl_t;
endpackage

// File: rtl/neuron_ctrl.sv
module neuron_ctrl #(
  parameter int NUM_IN = 30,
  localparam int CW = $clog2(NUM_IN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strobe,
  output neuron_pkg::ctrl_t ctrl,
  output logic [CW-1:0]     idx
);
  logic busy;
  logic [CW-1:0] cnt;
  logic lastStep;

  assign lastStep = (cnt == CW'(NUM_IN));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (strobe) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (lastStep) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    ctrl.latch = !busy && strobe;
    ctrl.accum = busy && !lastStep;
    ctrl.slope = busy && lastStep;
  end

  assign idx = cnt;
endmodule

// File: rtl/neuron_datapath.sv
module neuron_datapath #(
  parameter int NUM_IN      = 30,
  parameter int W_BITS      = 9,
  parameter int P_BITS      = 10,
  parameter int REST        = 32,
  parameter int THRESH      = 128,
  parameter int AFTER       = 18,
  parameter int LOW_BOUND   = -128,
  parameter int ATTEN_SHIFT = 2,
  localparam int CW    = $clog2(NUM_IN + 1),
  localparam int DEPTH = NUM_IN + 2,
  localparam int AW    = $clog2(DEPTH),
  localparam int SW    = P_BITS + 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  neuron_pkg::ctrl_t        ctrl,
  input  logic [CW-1:0]            idx,
  input  logic [NUM_IN-1:0]        spikeIn,
  input  logic                     refMode,
  input  logic                     wrEn,
  input  logic [AW-1:0]            wrAddr,
  input  logic signed [W_BITS-1:0] wrData,
  output logic                     spikeOut,
  output logic                     sliceDone,
  output logic                     inRefractory,
  output logic signed [P_BITS-1:0] potOut
);
  localparam logic signed [SW-1:0] REST_S  = SW'(REST);
  localparam logic signed [SW-1:0] THR_S   = SW'(THRESH);
  localparam logic signed [SW-1:0] LOW_S   = SW'(LOW_BOUND);
  localparam logic signed [SW-1:0] HIGH_S  = SW'((1 << (P_BITS - 1)) - 1);
  localparam logic signed [P_BITS-1:0] AFTER_P = P_BITS'(AFTER);
  localparam logic signed [P_BITS-1:0] REST_P  = P_BITS'(REST);

  typedef enum logic {OPER, REFR} nstate_t;

  logic signed [W_BITS-1:0] store [DEPTH];
  logic [NUM_IN:0]          sliceSpikes;
  logic signed [P_BITS-1:0] pot;
  nstate_t                  nState;

  logic signed [W_BITS-1:0] weight, wEff, riseSlope, fallSlope;
  logic signed [SW-1:0]     potX, accSum, riseSum, fallSum;
  logic signed [P_BITS-1:0] slopeNext;
  nstate_t                  stateNext;
  logic                     fireNow;

  function automatic logic signed [P_BITS-1:0] clampPot(input logic signed [SW-1:0] v);
    if (v > HIGH_S)      return HIGH_S[P_BITS-1:0];
    else if (v < LOW_S)  return LOW_S[P_BITS-1:0];
    else                 return v[P_BITS-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (wrEn && ({1'b0, wrAddr} < (AW + 1)'(DEPTH))) store[wrAddr] <= wrData;
  end

  assign weight    = store[idx];
  assign riseSlope = store[NUM_IN];
  assign fallSlope = store[NUM_IN + 1];
  assign potX      = SW'(pot);

  always_comb begin
    if (!sliceSpikes[idx])          wEff = '0;
    else if (nState == OPER)        wEff = weight;
    else if (refMode)               wEff = weight >>> ATTEN_SHIFT;
    else                            wEff = '0;
  end

  assign accSum  = potX + SW'(wEff);
  assign riseSum = potX + SW'(riseSlope);
  assign fallSum = potX - SW'(fallSlope);

  always_comb begin
    slopeNext = pot;
    stateNext = nState;
    fireNow   = 1'b0;
    if (nState == OPER) begin
      if (potX >= THR_S) begin
        fireNow   = 1'b1;
        slopeNext = AFTER_P;
        stateNext = REFR;
      end else if (potX > REST_S) begin
        slopeNext = (fallSum < REST_S) ? REST_P : clampPot(fallSum);
      end else if (potX < REST_S) begin
        slopeNext = (riseSum > REST_S) ? REST_P : clampPot(riseSum);
      end
    end else begin
      slopeNext = clampPot(riseSum);
      if (riseSum >= REST_S) stateNext = OPER;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pot         <= REST_P;
      nState      <= OPER;
      sliceSpikes <= '0;
      spikeOut    <= 1'b0;
      sliceDone   <= 1'b0;
    end else begin
      spikeOut  <= 1'b0;
      sliceDone <= 1'b0;
      if (ctrl.latch) sliceSpikes <= {1'b0, spikeIn};
      if (ctrl.accum) pot <= clampPot(accSum);
      if (ctrl.slope) begin
        pot       <= slopeNext;
        nState    <= stateNext;
        spikeOut  <= fireNow;
        sliceDone <= 1'b1;
      end
    end
  end

  assign inRefractory = (nState == REFR);
  assign potOut       = pot;
endmodule

// File: rtl/spike_neuron.sv
module spike_neuron #(
  parameter int NUM_IN      = 30,
  parameter int W_BITS      = 9,
  parameter int P_BITS      = 10,
  parameter int REST        = 32,
  parameter int THRESH      = 128,
  parameter int AFTER       = 18,
  parameter int LOW_BOUND   = -128,
  parameter int ATTEN_SHIFT = 2,
  localparam int AW = $clog2(NUM_IN + 2),
  localparam int CW = $clog2(NUM_IN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strobe,
  input  logic [NUM_IN-1:0] spikeIn,
  input  logic              refMode,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [W_BITS-1:0] wrData,
  output logic              spikeOut,
  output logic              sliceDone,
  output logic              inRefractory,
  output logic [P_BITS-1:0] potOut
);
  neuron_pkg::ctrl_t ctrl;
  logic [CW-1:0]     idx;

  neuron_ctrl #(.NUM_IN(NUM_IN)) u_ctrl (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ctrl(ctrl), .idx(idx)
  );

  neuron_datapath #(
    .NUM_IN(NUM_IN), .W_BITS(W_BITS), .P_BITS(P_BITS), .REST(REST),
    .THRESH(THRESH), .AFTER(AFTER), .LOW_BOUND(LOW_BOUND),
    .ATTEN_SHIFT(ATTEN_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .idx(idx), .spikeIn(spikeIn),
    .refMode(refMode), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .spikeOut(spikeOut), .sliceDone(sliceDone),
    .inRefractory(inRefractory), .potOut(potOut)
  );
endmodule

// File: rtl/spike_neuron_chk.sv
module spike_neuron_chk #(
  parameter int P_BITS    = 10,
  parameter int AFTER     = 18,
  parameter int LOW_BOUND = -128
) (
  input logic              clk,
  input logic              rstN,
  input logic              spikeOut,
  input logic              sliceDone,
  input logic              inRefractory,
  input logic [P_BITS-1:0] potOut
);
  AST_SPIKE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    spikeOut |=> !spikeOut); // R5
  AST_SPIKE_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    spikeOut |-> sliceDone); // R5
  AST_FIRE_RESETS_POT: assert property (@(posedge clk) disable iff (!rstN)
    spikeOut |-> (inRefractory && potOut == P_BITS'(AFTER))); // R5
  AST_REFR_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inRefractory) |-> spikeOut); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    sliceDone |=> !sliceDone); // R2
  AST_POT_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    $signed(potOut) >= LOW_BOUND); // R9
endmodule

bind spike_neuron spike_neuron_chk #(
  .P_BITS(P_BITS), .AFTER(AFTER), .LOW_BOUND(LOW_BOUND)
) u_chk (
  .clk(clk), .rstN(rstN), .spikeOut(spikeOut), .sliceDone(sliceDone),
  .inRefractory(inRefractory), .potOut(potOut)
);

// File: tb/spike_neuron_bench.sv
module spike_neuron_bench;
  localparam int N  = 4;
  localparam int AW = $clog2(N + 2);

  logic clk = 0, rstN = 0, strobe = 0, refMode = 0, wrEn = 0;
  logic [N-1:0] spikeIn = '0;
  logic [AW-1:0] wrAddr = '0;
  logic [8:0] wrData = '0;
  logic spikeOut, sliceDone, inRefractory;
  logic [9:0] potOut;

  int total = 0, bad = 0, cycles = 0;
  bit sawSpike;
  int sliceLen;

  always #10 clk = ~clk;

  spike_neuron #(.NUM_IN(N), .ATTEN_SHIFT(1)) u_spike_neuron (
    .clk(clk), .rstN(rstN), .strobe(strobe), .spikeIn(spikeIn),
    .refMode(refMode), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .spikeOut(spikeOut), .sliceDone(sliceDone),
    .inRefractory(inRefractory), .potOut(potOut)
  );

  // vector: spikes[16:13] mode[12] pot[11:2] spike[1] refr[0]
  localparam logic [16:0] VEC [12] = '{
    {4'b0000, 1'b0, 10'd32, 1'b0, 1'b0},  // R4 at rest, stays
    {4'b0001, 1'b0, 10'd70, 1'b0, 1'b0},  // R3 +40, R4 -2
    {4'b0000, 1'b0, 10'd68, 1'b0, 1'b0},  // R4 leak
    {4'b0011, 1'b0, 10'd18, 1'b1, 1'b1},  // R3 R5 two weights fire
    {4'b0010, 1'b0, 10'd21, 1'b0, 1'b1},  // R7 ignored, R6 +3
    {4'b0010, 1'b1, 10'd74, 1'b0, 1'b0},  // R8 +50, R6 back to operational
    {4'b0100, 1'b0, 10'd17, 1'b0, 1'b0},  // R3 -60, R4 rise below rest
    {4'b0000, 1'b0, 10'd20, 1'b0, 1'b0},  // R4
    {4'b0000, 1'b0, 10'd23, 1'b0, 1'b0},  // R4
    {4'b1000, 1'b0, 10'd31, 1'b0, 1'b0},  // R3 +5, R4 +3
    {4'b0000, 1'b0, 10'd32, 1'b0, 1'b0},  // R4 capped at rest
    {4'b0001, 1'b1, 10'd70, 1'b0, 1'b0}   // R8 mode no effect when operational
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeWord(input int a, input int d);
    @(negedge clk);
    wrEn = 1; wrAddr = AW'(a); wrData = 9'(d);
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic runSlice(input logic [N-1:0] sp, input logic md);
    @(negedge clk);
    spikeIn = sp; refMode = md; strobe = 1;
    sliceLen = 0; sawSpike = 0;
    @(negedge clk);
    strobe = 0;
    sliceLen = 1;
    while (!sliceDone && sliceLen < 50) begin
      @(negedge clk);
      sliceLen++;
    end
    sawSpike = spikeOut;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(potOut == 10'd32, "R1 pot", $signed(potOut), 32);
    check(!inRefractory, "R1 refr", inRefractory, 0);
    check(!spikeOut && !sliceDone, "R1 outputs", spikeOut + sliceDone, 0);
    rstN = 1;
    // R10 store layout: weights 0..3, rising slope at 4, falling at 5
    writeWord(0, 40); writeWord(1, 100); writeWord(2, -60);
    writeWord(3, 5);  writeWord(4, 3);   writeWord(5, 2);

    for (int i = 0; i < 12; i++) begin
      runSlice(VEC[i][16:13], VEC[i][12]);
      check(sliceLen == N + 2, $sformatf("R2 slice length v%0d", i), sliceLen, N + 2);
      check($signed(potOut) == $signed(VEC[i][11:2]), $sformatf("R3/R4 pot v%0d", i),
            $signed(potOut), $signed(VEC[i][11:2]));
      check(sawSpike == VEC[i][1], $sformatf("R5 spike v%0d", i), sawSpike, VEC[i][1]);
      check(inRefractory == VEC[i][0], $sformatf("R6 refr v%0d", i), inRefractory, VEC[i][0]);
      @(negedge clk);
      check(!spikeOut && !sliceDone, $sformatf("R2 R5 one cycle v%0d", i),
            spikeOut + sliceDone, 0);
    end

    // R9: clamp at the floor, pot 70 then -250 -> -128, then +3
    writeWord(2, -250);
    runSlice(4'b0100, 0);
    check($signed(potOut) == -125, "R9 floor clamp", $signed(potOut), -125);
    check(!inRefractory, "R9 refr", inRefractory, 0);

    // R2: a second strobe during a busy slice is ignored
    @(negedge clk);
    spikeIn = 4'b0000; strobe = 1;
    @(negedge clk);
    strobe = 0;
    @(negedge clk);
    strobe = 1;
    @(negedge clk);
    strobe = 0;
    begin
      int dones = 0;
      for (int k = 0; k < 3 * N; k++) begin
        if (sliceDone) dones++;
        @(negedge clk);
      end
      check(dones == 1, "R2 busy strobe ignored", dones, 1);
    end
    check($signed(potOut) == -122, "R2 R4 single slice applied", $signed(potOut), -122);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule